// File: doc/BRIEF.md
# Peripheral Pin Sleep-Hold Controller

This block decides, for 22 peripheral pins, whether each pin drives and what it drives, across entry into sleep, the sleep period itself, and the wake-up that follows. In normal running, a software-written direction register selects which pins drive, and each driving pin carries the value from its peripheral. Software also programs a second, sleep-mode direction register ahead of time. When a sleep request arrives, the block captures that value and freezes the pins. A sleep bit of 0 makes its pin drive low. A sleep bit of 1 leaves its pin as an input.

The sleep request acts as a reset for the normal direction register, and so does the soft-reset input. Neither one touches the sleep-mode register, so its programmed value survives into sleep. When the request goes away, a hold flag is raised and the pins stay frozen. This gives software time to rebuild the peripheral setup. Software then writes a one to the hold flag, and the pins go back to normal control. Only the hard reset clears the sleep-mode register. This models the loss of its contents when power is removed.

Register access is a single-cycle write strobe with a 2-bit address. Read data is combinational on the address.

Top module: `pin_sleep_hold_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the following hold after that edge:
  - The normal direction register reads 0.
  - The sleep direction register and its latched copy read all ones.
  - The hold flag is 0.
  - Every `pin_oe` and `pin_out` bit is 0.
- R2: A clock edge with `soft_rst_n` low clears the normal direction register to 0. This makes every pin an input in normal running. The sleep direction register and the hold flag are left unchanged.
- R3: At the first clock edge where `sleep_req` is high while not already asleep, the block does two things:
  - It copies the sleep direction register into a latch.
  - It enters sleep control, and `pin_oe` becomes the bitwise inverse of the latched value.
- R4: Under sleep control (asleep, or holding after wake), the following apply:
  - `pin_out` is all zeros.
  - A latched bit of 0 drives its pin low (`pin_oe`=1).
  - A latched bit of 1 makes its pin an input.
  - Writing the sleep direction register while asleep does not change the pins.
- R5: Writes to the normal direction register are ignored while `sleep_req` is high or the block is asleep. Every edge in that state clears the register, and it reads 0.
- R6: On the first clock edge where `sleep_req` is low while asleep, the hold flag becomes 1. The pins stay in the latched state while the flag is 1. This holds even if the normal direction register is rewritten.
- R7: Writing address 2 with bit 0 set clears the hold flag at that edge. Pins then follow normal control. Writing address 2 with bit 0 clear has no effect.
- R8: Under normal control, `pin_oe` equals the normal direction register. `pin_out` equals `periph_dout` AND the normal direction register.
- R9: Reads are combinational on `addr`:
  - Address 0 returns the normal direction register.
  - Address 1 returns the sleep direction register.
  - Address 2 returns the hold flag in bit 0, with the other bits 0.
  - Address 3 returns 0.
  - A write to address 0 or 1 stores all 22 data bits.
- R10: A `sleep_req` while holding re-enters sleep and re-latches the sleep direction register. If a hold-clear write comes in the same cycle as `sleep_req`, the sleep request wins.
- R11: The sleep direction register keeps its value through soft reset, sleep entry and the hold period. Only the hard reset restores it to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst_n | input | 1 | Soft reset of the normal direction register, synchronous, active low |
| sleep_req | input | 1 | Sleep request, high while sleep is wanted |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 2 | Register select: 0 normal dir, 1 sleep dir, 2 hold flag |
| wdata | input | 22 | Write data |
| rdata | output | 22 | Read data for `addr` |
| periph_dout | input | 22 | Drive values from the peripherals |
| pin_oe | output | 22 | Pin output enable, 1 = pin drives |
| pin_out | output | 22 | Pin output data |
| hold_flag | output | 1 | Pins held in sleep state after wake |

## Verification
The hardest state to reach from the ports is a hold period in which software has already rewritten the normal direction register. The pins must still ignore that new value until the write-one-to-clear. A second hard case is a sleep request that lands in the same cycle as the hold-clear write. The stimulus reaches both by programming distinct patterns into the two direction registers first, then stepping `sleep_req` high and low. During the hold, the bench writes the normal register, writes zero and then one to the hold address, and finally re-raises `sleep_req` together with a clear. A reference model in the bench scores every cycle on pins, flag and read data.

// File: rtl/pshc_pkg.sv
// Package: shared state type and register addresses for the pin sleep-hold
// controller. Assumes a 2-bit register address space.
package pshc_pkg;
    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_SLEEP = 2'd1,
        PS_HOLD  = 2'd2
    } pshc_state_t;

    localparam int REG_NDIR = 0;
    localparam int REG_SDIR = 1;
    localparam int REG_HOLD = 2;
endpackage

// File: rtl/pshc_regs.sv
// Module: software-visible direction registers and read mux.
// The normal register clears on hard reset, soft reset and the sleep reset.
// The sleep register clears (to all ones) on hard reset only.
// Assumes addr/wdata are stable across the single-cycle write strobe.
module pshc_regs #(
    parameter int NUM_PINS = 22,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst_n,
    input  logic                sleep_rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    input  logic                hold_flag,
    output logic [NUM_PINS-1:0] ndir_q,
    output logic [NUM_PINS-1:0] sdir_q,
    output logic [NUM_PINS-1:0] rdata,
    output logic                hold_clr
);
    import pshc_pkg::*;

    logic sel_ndir, sel_sdir, sel_hold;

    // Address decode for the three registers.
    always_comb begin
        sel_ndir = (addr == ADDR_W'(REG_NDIR));
        sel_sdir = (addr == ADDR_W'(REG_SDIR));
        sel_hold = (addr == ADDR_W'(REG_HOLD));
    end

    // Write-one-to-clear request for the hold flag.
    assign hold_clr = wr_en && sel_hold && wdata[0];

    // Normal direction register: cleared by any of the three resets.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n || sleep_rst)
            ndir_q <= '0;
        else if (wr_en && sel_ndir)
            ndir_q <= wdata;
    end

    // Sleep direction register: only the hard reset restores it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sdir_q <= '1;
        else if (wr_en && sel_sdir)
            sdir_q <= wdata;
    end

    // Combinational read mux; unused bits and addresses read zero.
    always_comb begin
        rdata = '0;
        if (sel_ndir)      rdata = ndir_q;
        else if (sel_sdir) rdata = sdir_q;
        else if (sel_hold) rdata[0] = hold_flag;
    end
endmodule

// File: rtl/pshc_seq.sv
// Module: sleep sequencer. Tracks run/sleep/hold and latches the sleep
// direction value on sleep entry. Assumes sleep_req is synchronous to clk.
module pshc_seq #(
    parameter int NUM_PINS = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                hold_clr,
    input  logic [NUM_PINS-1:0] sdir_q,
    output logic [NUM_PINS-1:0] latch_q,
    output logic                in_sleep,
    output logic                sleep_ctl,
    output logic                hold_flag
);
    import pshc_pkg::*;

    pshc_state_t state_q, state_d;
    logic        do_latch;

    // Next-state selection; a sleep request outranks a hold clear.
    always_comb begin
        state_d  = state_q;
        do_latch = 1'b0;
        if (sleep_req) begin
            state_d  = PS_SLEEP;
            do_latch = (state_q != PS_SLEEP);
        end else if (state_q == PS_SLEEP) begin
            state_d = PS_HOLD;
        end else if (state_q == PS_HOLD && hold_clr) begin
            state_d = PS_RUN;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // Sleep direction latch, captured once per sleep entry.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '1;
        else if (do_latch) latch_q <= sdir_q;
    end

    // Decoded status outputs.
    always_comb begin
        in_sleep  = (state_q == PS_SLEEP);
        hold_flag = (state_q == PS_HOLD);
        sleep_ctl = (state_q != PS_RUN);
    end
endmodule

// File: rtl/pshc_pin_mux.sv
// Module: per-pin selection between normal and sleep control.
// Assumes oe is active high; sleep control drives 0 on every driving pin.
module pshc_pin_mux #(
    parameter int NUM_PINS = 22
) (
    input  logic                sleep_ctl,
    input  logic [NUM_PINS-1:0] latch_q,
    input  logic [NUM_PINS-1:0] ndir_q,
    input  logic [NUM_PINS-1:0] periph_dout,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out
);
    // One selector per pin.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign pin_oe[i]  = sleep_ctl ? ~latch_q[i] : ndir_q[i];
        assign pin_out[i] = sleep_ctl ? 1'b0 : (periph_dout[i] & ndir_q[i]);
    end
endmodule

// File: rtl/pin_sleep_hold_ctrl.sv
// Module: top of the peripheral pin sleep-hold controller.
// It wires the registers, the sleep sequencer and the pin selectors.
// The sleep reset to the normal direction register is active while the
// request is high or the block is asleep.
module pin_sleep_hold_ctrl #(
    parameter int NUM_PINS = 22,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst_n,
    input  logic                sleep_req,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] rdata,
    input  logic [NUM_PINS-1:0] periph_dout,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                hold_flag
);
    logic [NUM_PINS-1:0] ndir_q, sdir_q, latch_q;
    logic                hold_clr, in_sleep, sleep_ctl, sleep_rst;

    // Sleep reset seen by the normal direction register.
    assign sleep_rst = sleep_req | in_sleep;

    pshc_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
        .sleep_rst(sleep_rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hold_flag(hold_flag), .ndir_q(ndir_q), .sdir_q(sdir_q),
        .rdata(rdata), .hold_clr(hold_clr)
    );

    pshc_seq #(.NUM_PINS(NUM_PINS)) seq_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .hold_clr(hold_clr), .sdir_q(sdir_q), .latch_q(latch_q),
        .in_sleep(in_sleep), .sleep_ctl(sleep_ctl), .hold_flag(hold_flag)
    );

    pshc_pin_mux #(.NUM_PINS(NUM_PINS)) mux_i (
        .sleep_ctl(sleep_ctl), .latch_q(latch_q), .ndir_q(ndir_q),
        .periph_dout(periph_dout), .pin_oe(pin_oe), .pin_out(pin_out)
    );
endmodule

// File: rtl/pshc_checker.sv
// Module: protocol checker for the pin sleep-hold controller, bound to the top.
module pshc_checker #(
    parameter int NUM_PINS = 22,
    parameter int ADDR_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sleep_req,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic                wdata0,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_out,
    input logic                hold_flag,
    input logic [NUM_PINS-1:0] ndir_q,
    input logic                in_sleep,
    input logic                sleep_ctl
);
    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (!hold_flag && ndir_q == '0 && !sleep_ctl && pin_oe == '0)); // R1
    AST_SLEEP_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n) sleep_ctl |-> (pin_out == '0)); // R4
    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (in_sleep && $past(in_sleep)) |-> $stable(pin_oe)); // R3
    AST_NDIR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) sleep_req |=> (ndir_q == '0)); // R5
    AST_HOLD_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n) (in_sleep && !sleep_req) |=> hold_flag); // R6
    AST_HOLD_W1C: assert property (@(posedge clk) disable iff (!rst_n) (hold_flag && wr_en && addr == ADDR_W'(2) && wdata0 && !sleep_req) |=> !sleep_ctl); // R7
    AST_NORMAL_OE: assert property (@(posedge clk) disable iff (!rst_n) !sleep_ctl |-> (pin_oe == ndir_q)); // R8
endmodule

bind pin_sleep_hold_ctrl pshc_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wr_en(wr_en),
    .addr(addr), .wdata0(wdata[0]), .pin_oe(pin_oe), .pin_out(pin_out),
    .hold_flag(hold_flag), .ndir_q(ndir_q), .in_sleep(in_sleep),
    .sleep_ctl(sleep_ctl)
);

// File: tb/pin_sleep_hold_ctrl_tb_top.sv
// Scoreboard bench: the driver task updates a requirement-level model and
// queues the expected outputs; the monitor compares 5 ns after each edge.
module pin_sleep_hold_ctrl_tb_top;
    localparam int N = 22;
    localparam logic [N-1:0] ONES = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0, soft_rst_n = 1'b1, sleep_req = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [N-1:0] wdata = '0, periph_dout = '0;
    logic [N-1:0] rdata, pin_oe, pin_out;
    logic hold_flag;

    always #10 clk = ~clk;

    pin_sleep_hold_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .sleep_req(sleep_req),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .periph_dout(periph_dout), .pin_oe(pin_oe), .pin_out(pin_out),
        .hold_flag(hold_flag)
    );

    typedef struct {
        logic [N-1:0] oe;
        logic [N-1:0] out;
        logic [N-1:0] rd;
        logic         hold;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int total = 0, bad = 0;
    bit finished = 0;

    // model state: 0 run, 1 sleep, 2 hold
    logic [N-1:0] m_ndir = '0, m_sdir = ONES, m_latch = ONES;
    int m_st = 0;

    task automatic step(input logic wr, input logic [1:0] ad, input logic [N-1:0] wd,
                        input logic sr, input logic soft_n, input logic hard_n,
                        input logic [N-1:0] dout, input string tag);
        exp_t e;
        logic clr;
        @(negedge clk);
        wr_en = wr; addr = ad; wdata = wd; sleep_req = sr;
        soft_rst_n = soft_n; rst_n = hard_n; periph_dout = dout;
        clr = wr && ad == 2'd2 && wd[0];
        if (!hard_n) begin
            m_ndir = '0; m_sdir = ONES; m_latch = ONES; m_st = 0;
        end else begin
            if (sr || !soft_n || m_st == 1) m_ndir = '0;
            else if (wr && ad == 2'd0) m_ndir = wd;
            if (sr) begin
                if (m_st != 1) m_latch = m_sdir;
                m_st = 1;
            end else if (m_st == 1) m_st = 2;
            else if (m_st == 2 && clr) m_st = 0;
            if (wr && ad == 2'd1) m_sdir = wd;
        end
        e.hold = (m_st == 2);
        e.oe   = (m_st != 0) ? ~m_latch : m_ndir;
        e.out  = (m_st != 0) ? '0 : (dout & m_ndir);
        case (ad)
            2'd0: e.rd = m_ndir;
            2'd1: e.rd = m_sdir;
            2'd2: e.rd = {{(N-1){1'b0}}, e.hold};
            default: e.rd = '0;
        endcase
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare one queued expectation per clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (pin_oe !== e.oe || pin_out !== e.out || rdata !== e.rd || hold_flag !== e.hold) begin
                    bad++;
                    $display("FAIL %s: oe=%h out=%h rd=%h hold=%b expected oe=%h out=%h rd=%h hold=%b",
                             e.tag, pin_oe, pin_out, rdata, hold_flag, e.oe, e.out, e.rd, e.hold);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [N-1:0] D0 = 22'h3FFFFF, D1 = 22'h123456;

    initial begin
        step(0, 0, '0, 0, 1, 0, D0, "R1 reset ndir");
        step(0, 1, '0, 0, 1, 0, D0, "R1 reset sdir");
        step(0, 2, '0, 0, 1, 1, D0, "R1 reset hold");
        step(1, 0, 22'h2AAAAA, 0, 1, 1, D0, "R8 normal write");
        step(0, 0, '0, 0, 1, 1, D1, "R8 normal drive pattern");
        step(1, 1, 22'h0F0F0F, 0, 1, 1, D1, "R9 sdir write/read");
        step(0, 3, '0, 0, 1, 1, D1, "R9 unused address");
        step(0, 1, '0, 0, 0, 1, D1, "R2 soft reset keeps sdir");
        step(0, 0, '0, 0, 1, 1, D1, "R2 soft reset cleared ndir");
        step(1, 0, 22'h155555, 0, 1, 1, D1, "R8 normal rewrite");
        step(0, 0, '0, 1, 1, 1, D1, "R3 sleep entry");
        step(1, 0, ONES, 1, 1, 1, D1, "R5 ndir write in sleep");
        step(1, 1, ONES, 1, 1, 1, D1, "R4 sdir write in sleep");
        step(0, 1, '0, 1, 1, 1, D0, "R11 sdir readable in sleep");
        step(0, 2, '0, 0, 1, 1, D0, "R6 hold set on wake");
        step(1, 0, 22'h3C3C3C, 0, 1, 1, D0, "R6 ndir write in hold");
        step(0, 2, '0, 0, 1, 1, D0, "R6 pins still latched");
        step(1, 2, 22'h3FFFFE, 0, 1, 1, D0, "R7 write zero no effect");
        step(1, 2, 22'h000001, 0, 1, 1, D0, "R7 w1c release");
        step(0, 0, '0, 0, 1, 1, D1, "R8 normal after release");
        step(0, 2, '0, 1, 1, 1, D1, "R3 second sleep");
        step(0, 2, '0, 0, 1, 1, D1, "R6 second hold");
        step(1, 1, 22'h00FF00, 0, 1, 1, D1, "R11 sdir reprogram in hold");
        step(1, 2, 22'h000001, 1, 1, 1, D1, "R10 sleep beats clear");
        step(0, 2, '0, 0, 1, 1, D1, "R10 relatched hold");
        step(1, 2, 22'h000001, 0, 1, 1, D1, "R7 release again");
        step(1, 0, ONES, 0, 1, 1, D0, "R9 full width write");
        step(0, 1, '0, 0, 1, 0, D0, "R11 hard reset sdir");
        step(0, 0, '0, 0, 1, 1, D0, "R1 after hard reset");
        repeat (2) @(posedge clk);
        #6;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule